// File: doc/BRIEF.md
# Tag Store with Equality Flag

The block is a synchronous tag memory for a cache controller. Each word holds a tag and its own valid bit. In a compare access, the tag stored at the presented address is tested against the tag on the data input. The result appears on an active-high match output one clock later.

The match output is held high whenever the block is not doing a compare. This covers a deselected block, a write, output enable asserted, and a clear in progress. Because of this, several blocks can drive one wired-AND hit line, and only a block that finds a miss pulls the line low.

Reads put the stored word on the data output one clock after the address. An explicit output-valid signal stands in for a high-impedance pad. A clear input sweeps the valid bits one entry per clock, so every tag becomes invalid after a full pass.

Top module: `tagMatchRam`

## Requirements
- R1: The store holds 2^ADDR_W words of DATA_W bits (ADDR_W = 13 gives 8192 words). The first and the last address each keep their own word.
- R2: A write happens at a rising edge only when chipSelN, writeEnN and clearN are all sampled in their write state: chipSelN = 0, writeEnN = 0 and clearN = 1. The write stores dataIn at addr and marks that entry valid.
- R3: While chipSelN is 1, matchOut is 1 in the same cycle.
- R4: While outEnN is 0, matchOut is 1 in the same cycle.
- R5: While writeEnN is 0, matchOut is 1 in the same cycle.
- R6: While clearN is 0, matchOut is 1. A write attempted while clearN is 0 is ignored: a later compare at that address misses.
- R7: Holding clearN at 0 for at least 2^ADDR_W consecutive cycles invalidates every entry. A compare against an invalid entry reports a miss (matchOut = 0).
- R8: A compare cycle has chipSelN = 0, writeEnN = 1, outEnN = 1 and clearN = 1. In a compare cycle whose previous cycle was also a compare, matchOut is 1 exactly when the entry at the previous cycle's addr is valid and equals the previous cycle's dataIn. In the first compare cycle after any other cycle, matchOut is 1.
- R9: A read cycle has chipSelN = 0, writeEnN = 1, outEnN = 0 and clearN = 1. In a read cycle whose previous cycle was also a read, dataOutValid is 1 and dataOut equals the word stored at the previous cycle's addr. In every other cycle, dataOutValid is 0 and dataOut is 0.
- R10: dataOutValid is 0 in any cycle with writeEnN = 0, including a cycle where chipSelN and writeEnN fall together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clearN | input | 1 | Active-low clear; sweeps valid bits and forces matchOut high |
| chipSelN | input | 1 | Active-low select |
| writeEnN | input | 1 | Active-low write enable |
| outEnN | input | 1 | Active-low output enable (read request) |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Write data and compare tag |
| dataOut | output | DATA_W | Read word, 0 when not driven |
| dataOutValid | output | 1 | High when dataOut is driven |
| matchOut | output | 1 | Tag equality flag, high when idle or forced |

## Verification
Compares are run back to back on one address with an equal tag, a tag differing in one bit, an entry never written, and an entry whose write was attempted during a clear. Together these separate a true hit from an equality test that ignores the valid bit or the blocked write. Each forcing input (select, output enable, write enable, clear) is raised inside a compare run, which shows that each one alone drives the flag high. Consecutive reads at the lowest and highest addresses check depth and latency. A read followed by a write, and a select and write asserted together, check that the output stays undriven. A long random mix of idle, write, compare and read cycles over a few addresses then checks the mode transitions against the bench model.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
  typedef struct packed {
    logic wrEn;
    logic cmpEn;
    logic rdEn;
    logic clrEn;
  } tagStrobe_t;
endpackage

// File: rtl/tagCtrl.sv
module tagCtrl
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              clearN,
  input  logic              chipSelN,
  input  logic              writeEnN,
  input  logic              outEnN,
  output tagStrobe_t        strobe,
  output logic [ADDR_W-1:0] clrIdx,
  output logic              forceMatch,
  output logic              outLive
);
  logic readNow;
  logic readLast;

  // Access decode from the pins of the current cycle
  always_comb begin
    strobe.clrEn = !clearN;
    strobe.wrEn  = clearN && !chipSelN && !writeEnN;
    strobe.cmpEn = clearN && !chipSelN && writeEnN && outEnN;
    strobe.rdEn  = clearN && !chipSelN && writeEnN && !outEnN;
  end

  assign readNow    = strobe.rdEn;
  assign forceMatch = chipSelN || !outEnN || !writeEnN || !clearN;
  assign outLive    = readNow && readLast;

  // Sweep index advances once per clock while clear is held low
  always_ff @(posedge clk) begin
    if (clearN) clrIdx <= '0;
    else        clrIdx <= clrIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    readLast <= readNow;
  end
endmodule

// File: rtl/tagPath.sv
module tagPath
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  tagStrobe_t        strobe,
  input  logic [ADDR_W-1:0] clrIdx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              cmpHit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] tagMem [DEPTH];
  logic              validMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) tagMem[addr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (strobe.clrEn)     validMem[clrIdx] <= 1'b0;
    else if (strobe.wrEn) validMem[addr]   <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.rdEn) rdData <= tagMem[addr];
  end

  // A non-compare cycle leaves the flag released (high)
  always_ff @(posedge clk) begin
    if (strobe.cmpEn) cmpHit <= validMem[addr] && (tagMem[addr] == dataIn);
    else              cmpHit <= 1'b1;
  end
endmodule

// File: rtl/tagMatchRam.sv
module tagMatchRam
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clearN,
  input  logic              chipSelN,
  input  logic              writeEnN,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutValid,
  output logic              matchOut
);
  tagStrobe_t        strobe;
  logic [ADDR_W-1:0] clrIdx;
  logic              forceMatch;
  logic              outLive;
  logic [DATA_W-1:0] rdData;
  logic              cmpHit;

  tagCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .clearN(clearN), .chipSelN(chipSelN), .writeEnN(writeEnN),
    .outEnN(outEnN), .strobe(strobe), .clrIdx(clrIdx),
    .forceMatch(forceMatch), .outLive(outLive)
  );

  tagPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .strobe(strobe), .clrIdx(clrIdx), .addr(addr),
    .dataIn(dataIn), .rdData(rdData), .cmpHit(cmpHit)
  );

  assign matchOut     = forceMatch | cmpHit;
  assign dataOutValid = outLive;
  assign dataOut      = outLive ? rdData : '0;
endmodule

// File: rtl/tagMatchRam_chk.sv
module tagMatchRam_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              clearN,
  input logic              chipSelN,
  input logic              writeEnN,
  input logic              outEnN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutValid,
  input logic              matchOut
);
  logic armed;
  logic cmpMode;
  logic rdMode;

  always_ff @(posedge clk) begin
    if (!clearN) armed <= 1'b1;
  end

  assign cmpMode = clearN && !chipSelN && writeEnN && outEnN;
  assign rdMode  = clearN && !chipSelN && writeEnN && !outEnN;

  // R3
  cs_idle_match_chk: assert property (@(posedge clk)
    disable iff (!clearN || armed !== 1'b1) chipSelN |-> matchOut);

  // R4
  oe_low_match_chk: assert property (@(posedge clk)
    disable iff (!clearN || armed !== 1'b1) !outEnN |-> matchOut);

  // R5
  we_low_match_chk: assert property (@(posedge clk)
    disable iff (!clearN || armed !== 1'b1) !writeEnN |-> matchOut);

  // R6
  clear_match_chk: assert property (@(posedge clk)
    disable iff (armed !== 1'b1) !clearN |-> matchOut);

  // R8
  miss_only_compare_chk: assert property (@(posedge clk)
    disable iff (!clearN || armed !== 1'b1) !matchOut |-> (cmpMode && $past(cmpMode)));

  // R9
  read_drive_chk: assert property (@(posedge clk)
    disable iff (!clearN || armed !== 1'b1) (rdMode && $past(rdMode)) |-> dataOutValid);

  // R9
  undriven_zero_chk: assert property (@(posedge clk)
    disable iff (!clearN || armed !== 1'b1) !dataOutValid |-> (dataOut == '0));

  // R10
  write_no_drive_chk: assert property (@(posedge clk)
    disable iff (!clearN || armed !== 1'b1) !writeEnN |-> !dataOutValid);
endmodule

bind tagMatchRam tagMatchRam_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .clearN(clearN), .chipSelN(chipSelN), .writeEnN(writeEnN),
  .outEnN(outEnN), .dataOut(dataOut), .dataOutValid(dataOutValid),
  .matchOut(matchOut)
);

// File: tb/sim_tagMatchRam.sv
module sim_tagMatchRam;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              clearN = 1'b1;
  logic              chipSelN = 1'b1;
  logic              writeEnN = 1'b1;
  logic              outEnN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              dataOutValid;
  logic              matchOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string phase = "R3";

  // Behavioural reference state
  logic [DATA_W-1:0] mMem [DEPTH];
  bit                mVld [DEPTH];
  bit                mLastCmpHit = 1'b1;
  bit                mLastRd = 1'b0;
  logic [DATA_W-1:0] mLastRdData = '0;
  int                mClrRun = 0;

  always #5 clk = ~clk;

  tagMatchRam #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .clearN(clearN), .chipSelN(chipSelN), .writeEnN(writeEnN),
    .outEnN(outEnN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutValid(dataOutValid), .matchOut(matchOut)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s (%s) cycle %0d: got %0h expected %0h", tag, phase, cycles, got, exp);
    end
  endtask

  // One cycle: drive pins after the falling edge, check, then advance the model
  task automatic step(bit cs, bit we, bit oe, bit clr, int a, int d);
    bit force_, rdNow, cmpNow, expDv;
    string mTag;
    @(negedge clk);
    chipSelN = cs; writeEnN = we; outEnN = oe; clearN = clr;
    addr = a[ADDR_W-1:0]; dataIn = d[DATA_W-1:0];
    #1;
    force_ = cs || !oe || !we || !clr;
    rdNow  = !cs && we && !oe && clr;
    cmpNow = !cs && we && oe && clr;
    if (!clr)     mTag = "R6";
    else if (cs)  mTag = "R3";
    else if (!we) mTag = "R5";
    else if (!oe) mTag = "R4";
    else          mTag = "R8";
    check(mTag, {31'd0, matchOut}, force_ ? 32'd1 : {31'd0, mLastCmpHit});
    expDv = rdNow && mLastRd;
    check(!we ? "R10" : "R9", {31'd0, dataOutValid}, {31'd0, expDv});
    check("R9", {24'd0, dataOut}, expDv ? {24'd0, mLastRdData} : 32'd0);
    // model advance for the coming rising edge
    mLastCmpHit = cmpNow ? (mVld[a] && mMem[a] == d[DATA_W-1:0]) : 1'b1;
    mLastRd = rdNow;
    mLastRdData = mMem[a];
    if (!clr) begin
      mClrRun++;
      if (mClrRun >= DEPTH) for (int i = 0; i < DEPTH; i++) mVld[i] = 1'b0;
    end else begin
      mClrRun = 0;
      if (!cs && !we) begin mMem[a] = d[DATA_W-1:0]; mVld[a] = 1'b1; end
    end
  endtask

  task automatic doClear(int extraWriteAddr);
    for (int i = 0; i < DEPTH + 2; i++) begin
      if (i == DEPTH + 1) step(0, 0, 1, 0, extraWriteAddr, 8'h5A); // R6 blocked write
      else step(0, 1, 1, 0, i % DEPTH, i);
    end
  endtask

  initial begin
    int wa [4];
    for (int i = 0; i < DEPTH; i++) begin mMem[i] = '0; mVld[i] = 1'b0; end
    wa[0] = 0; wa[1] = 7; wa[2] = 8; wa[3] = DEPTH - 1;
    // R3: deselected start
    step(1, 1, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0, 0);
    phase = "R6"; doClear(5);
    phase = "R2"; // R1: first and last address written
    step(0, 0, 1, 1, 0, 8'h3C);
    step(0, 0, 1, 1, DEPTH - 1, 8'hA5);
    step(0, 0, 1, 1, 7, 8'h11);
    step(0, 0, 1, 1, 8, 8'hFF);
    phase = "R8";
    step(0, 1, 1, 1, 7, 8'h11);
    step(0, 1, 1, 1, 7, 8'h10);   // hit visible here
    step(0, 1, 1, 1, 8, 8'hFF);   // miss visible here
    step(0, 1, 1, 1, 0, 8'h3C);
    phase = "R7";
    step(0, 1, 1, 1, 9, 8'h00);   // unwritten entry
    phase = "R6";
    step(0, 1, 1, 1, 5, 8'h5A);   // blocked write
    phase = "R4";
    step(0, 1, 0, 1, 7, 8'h00);
    phase = "R5";
    step(0, 0, 1, 1, 9, 8'h42);
    step(0, 1, 1, 1, 9, 8'h00);
    phase = "R8";
    step(0, 1, 1, 1, 9, 8'h42);
    step(1, 1, 1, 1, 0, 0);
    phase = "R1";
    step(0, 1, 0, 1, 0, 0);
    step(0, 1, 0, 1, DEPTH - 1, 0);
    step(0, 1, 0, 1, 7, 0);
    phase = "R10";
    step(0, 0, 0, 1, 7, 8'h11);
    step(1, 1, 1, 1, 0, 0);
    step(0, 0, 0, 1, 8, 8'hFF);
    step(1, 1, 1, 1, 0, 0);
    phase = "R8";
    for (int n = 0; n < 400; n++) begin
      int a, d, mode;
      a = wa[$urandom % 4];
      mode = $urandom % 4;
      d = ($urandom % 2 == 0) ? int'(mMem[a]) : int'($urandom % 256);
      case (mode)
        0: step(1, $urandom % 2, $urandom % 2, 1, a, d);
        1: step(0, 0, $urandom % 2, 1, a, d);
        2: step(0, 1, 1, 1, a, d);
        default: step(0, 1, 0, 1, a, d);
      endcase
    end
    phase = "R7"; doClear(6);
    step(0, 1, 1, 1, 7, int'(mMem[7]));
    step(0, 1, 1, 1, 6, 8'h5A);
    step(1, 1, 1, 1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule